// File: doc/BRIEF.md
# Bidirectional Pin Boundary Scan Segment

This block is the slice of a boundary scan register that serves a group of bidirectional or three-state pads. Each pad owns two cells in the serial chain: one samples the value arriving from the pad and one holds the value to drive onto the pad. A small bank of shared enable cells decides which pads actually drive. Pad `i` answers to enable cell `i mod NCTL`, so one enable cell switches a whole group of pads. The tap state decoder and the instruction decoder are outside the block. They appear here as plain level inputs: test reset, capture, shift, update, register select, external-test mode and float mode.

In functional mode the pads carry the core's data and enables unchanged. In external-test mode the pad data comes from the drive latches and the pad enables come from the shared enable latches. In float mode every pad enable is forced off.

Two reset paths protect the board. Power-on reset clears the drive latches and makes the block ignore all scan clock activity. Test reset clears the latches as well. A bus-clock watchdog arms when external-test mode is left. If the external reset input stays quiet for too long, the watchdog raises an internal reset request.

Top module: `bs_bidir_chain`

## Requirements
- R1: With `instr_extest` and `instr_highz` both low, `pad_out` equals `core_out` and `pad_oe` equals `core_oe`.
- R2: On each rising `tck` edge with `shift_dr` and `dr_sel` high, the chain moves one cell from `tdi` toward `tdo`. Chain position 0 drives `tdo` and the last position takes `tdi`. Pad `i` input cell sits at position 2i and its drive cell at 2i+1. Enable cell k sits at position 2*NPIN+k.
- R3: On a rising `tck` edge with `capture_dr` and `dr_sel` high, each cell loads the value it observes. Input cells load `pad_in[i]`. Drive cells load the current `pad_out[i]`. Enable cells load their own current latch value.
- R4: Drive and enable latches load from the chain only on a falling `tck` edge while `update_dr` and `dr_sel` are high. In external-test mode `pad_out` does not move while data shifts.
- R5: With `instr_extest` high and `instr_highz` low, `pad_out[i]` is the drive latch of pad i and `pad_oe[i]` is enable latch `i mod NCTL`.
- R6: With `instr_highz` high, every bit of `pad_oe` is 0 whatever the enable latches hold, and `pad_out` equals `core_out`.
- R7: While `tap_reset` is high, all drive and enable latches read 0, so in external-test mode no pad is driven.
- R8: While `por` is high, all latches read 0 and capture, shift and update on `tck` have no effect.
- R9: After `instr_extest` falls, `int_rst` rises on the (SYNC+10)th rising `clk` edge unless `ext_rst` has been seen. It is still low on the (SYNC+9)th edge.
- R10: `ext_rst` high at a `clk` edge disarms the watchdog and clears `int_rst`. A pulse by the (SYNC+8)th edge after the exit keeps `int_rst` low.
- R11: While `por` is high the watchdog stays idle, so an exit from external-test mode during power-on reset never raises `int_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Scan clock |
| tdi | input | 1 | Serial data into the chain |
| tdo | output | 1 | Serial data out of chain position 0 |
| por | input | 1 | Power-on reset, active high, asynchronous |
| tap_reset | input | 1 | Tap is in its test reset state |
| capture_dr | input | 1 | Tap is in data-capture state |
| shift_dr | input | 1 | Tap is in data-shift state |
| update_dr | input | 1 | Tap is in data-update state |
| dr_sel | input | 1 | This register is the selected data register |
| instr_extest | input | 1 | External-test instruction active |
| instr_highz | input | 1 | Float instruction active |
| core_out | input | NPIN | Functional pad data from the core |
| core_oe | input | NPIN | Functional pad enables from the core |
| pad_in | input | NPIN | Values seen at the pads |
| pad_out | output | NPIN | Data to the pad drivers |
| pad_oe | output | NPIN | Enables to the pad drivers |
| clk | input | 1 | Bus clock for the exit watchdog |
| ext_rst | input | 1 | External system reset seen, active high |
| int_rst | output | 1 | Internal reset request from the watchdog |

## Verification
The hardest case to reach from the ports is the exact edge on which the exit watchdog fires. It sits behind a synchroniser and lives on a clock unrelated to `tck`. The stimulus drops `instr_extest` on a falling bus clock edge and then counts rising edges from that point. It samples `int_rst` one edge before and exactly on the (SYNC+10)th edge. A second exit, made by switching to float mode, pulses `ext_rst` at the edge that closes the allowed window to show the request never appears. A third exit happens while `por` is high, alongside a full shift and update that must leave the pads undriven.

// File: rtl/bs_pkg.sv
`timescale 1ns/1ps
package bs_pkg;

  typedef enum logic [1:0] {
    PM_FUNC  = 2'd0,
    PM_DRIVE = 2'd1,
    PM_FLOAT = 2'd2
  } pin_mode_t;

  // enable group that serves a given pad
  function automatic int grp_of(input int pin, input int ngrp);
    return pin % ngrp;
  endfunction

endpackage

// File: rtl/bs_cap_cell.sv
`timescale 1ns/1ps
module bs_cap_cell (
  input  logic tck,
  input  logic cap_en,
  input  logic sh_en,
  input  logic cap_d,
  input  logic si,
  output logic so
);
  logic q;

  always_ff @(posedge tck) begin
    if (cap_en)      q <= cap_d;
    else if (sh_en)  q <= si;
  end

  assign so = q;
endmodule

// File: rtl/bs_drv_cell.sv
`timescale 1ns/1ps
module bs_drv_cell (
  input  logic tck,
  input  logic clr,
  input  logic cap_en,
  input  logic sh_en,
  input  logic upd_en,
  input  logic cap_d,
  input  logic si,
  output logic so,
  output logic drv
);
  logic q;

  always_ff @(posedge tck) begin
    if (cap_en)      q <= cap_d;
    else if (sh_en)  q <= si;
  end

  // output latch moves on the falling edge so pads never see the shift
  always_ff @(negedge tck or posedge clr) begin
    if (clr)         drv <= 1'b0;
    else if (upd_en) drv <= q;
  end

  assign so = q;
endmodule

// File: rtl/bs_pin_mux.sv
`timescale 1ns/1ps
module bs_pin_mux
  import bs_pkg::*;
(
  input  pin_mode_t mode,
  input  logic      core_out,
  input  logic      core_oe,
  input  logic      cell_out,
  input  logic      cell_oe,
  output logic      pad_out,
  output logic      pad_oe
);
  always_comb begin
    unique case (mode)
      PM_DRIVE: begin pad_out = cell_out; pad_oe = cell_oe; end
      PM_FLOAT: begin pad_out = core_out; pad_oe = 1'b0;    end
      default:  begin pad_out = core_out; pad_oe = core_oe; end
    endcase
  end
endmodule

// File: rtl/bs_exit_watch.sv
`timescale 1ns/1ps
module bs_exit_watch #(
  parameter int SYNC  = 2,
  parameter int LIMIT = 10
) (
  input  logic clk,
  input  logic por,
  input  logic mode_flag,
  input  logic ext_rst,
  output logic int_rst
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [SYNC-1:0] sy;
  logic            sy_d;
  logic            exit_pulse;
  logic            armed;
  logic [CW-1:0]   cnt;

  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      sy   <= '0;
      sy_d <= 1'b0;
    end else begin
      sy   <= {sy[SYNC-2:0], mode_flag};
      sy_d <= sy[SYNC-1];
    end
  end

  assign exit_pulse = sy_d & ~sy[SYNC-1];

  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      armed   <= 1'b0;
      cnt     <= '0;
      int_rst <= 1'b0;
    end else if (ext_rst) begin
      armed   <= 1'b0;
      cnt     <= '0;
      int_rst <= 1'b0;
    end else if (armed) begin
      if (cnt == CW'(LIMIT - 1)) begin
        int_rst <= 1'b1;
        armed   <= 1'b0;
        cnt     <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (exit_pulse) begin
      armed <= 1'b1;
      cnt   <= CW'(1);
    end
  end
endmodule

// File: rtl/bs_bidir_chain.sv
`timescale 1ns/1ps
module bs_bidir_chain
  import bs_pkg::*;
#(
  parameter int NPIN  = 8,
  parameter int NCTL  = 5,
  parameter int SYNC  = 2,
  parameter int LIMIT = 10
) (
  input  logic            tck,
  input  logic            tdi,
  output logic            tdo,
  input  logic            por,
  input  logic            tap_reset,
  input  logic            capture_dr,
  input  logic            shift_dr,
  input  logic            update_dr,
  input  logic            dr_sel,
  input  logic            instr_extest,
  input  logic            instr_highz,
  input  logic [NPIN-1:0] core_out,
  input  logic [NPIN-1:0] core_oe,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  input  logic            clk,
  input  logic            ext_rst,
  output logic            int_rst
);
  localparam int NCELL = 2 * NPIN + NCTL;
  localparam int CBASE = 2 * NPIN;

  logic             rst_any;
  logic             cap_en, sh_en, upd_en;
  logic [NCELL:0]   chain;
  logic [NPIN-1:0]  out_lat;
  logic [NPIN-1:0]  grp_oe;
  logic [NCTL-1:0]  ctl_lat;
  pin_mode_t        mode;

  assign rst_any = por | tap_reset;
  assign cap_en  = capture_dr & dr_sel & ~rst_any;
  assign sh_en   = shift_dr   & dr_sel & ~rst_any;
  assign upd_en  = update_dr  & dr_sel & ~rst_any;

  assign chain[NCELL] = tdi;
  assign tdo          = chain[0];

  always_comb begin
    if (instr_highz)       mode = PM_FLOAT;
    else if (instr_extest) mode = PM_DRIVE;
    else                   mode = PM_FUNC;
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    localparam int G = grp_of(i, NCTL);

    bs_cap_cell u_in (
      .tck    (tck),
      .cap_en (cap_en),
      .sh_en  (sh_en),
      .cap_d  (pad_in[i]),
      .si     (chain[2*i+1]),
      .so     (chain[2*i])
    );

    bs_drv_cell u_out (
      .tck    (tck),
      .clr    (rst_any),
      .cap_en (cap_en),
      .sh_en  (sh_en),
      .upd_en (upd_en),
      .cap_d  (pad_out[i]),
      .si     (chain[2*i+2]),
      .so     (chain[2*i+1]),
      .drv    (out_lat[i])
    );

    assign grp_oe[i] = ctl_lat[G];

    bs_pin_mux u_mux (
      .mode     (mode),
      .core_out (core_out[i]),
      .core_oe  (core_oe[i]),
      .cell_out (out_lat[i]),
      .cell_oe  (grp_oe[i]),
      .pad_out  (pad_out[i]),
      .pad_oe   (pad_oe[i])
    );
  end

  for (genvar k = 0; k < NCTL; k++) begin : g_ctl
    bs_drv_cell u_ctl (
      .tck    (tck),
      .clr    (rst_any),
      .cap_en (cap_en),
      .sh_en  (sh_en),
      .upd_en (upd_en),
      .cap_d  (ctl_lat[k]),
      .si     (chain[CBASE+k+1]),
      .so     (chain[CBASE+k]),
      .drv    (ctl_lat[k])
    );
  end

  bs_exit_watch #(.SYNC(SYNC), .LIMIT(LIMIT)) u_watch (
    .clk       (clk),
    .por       (por),
    .mode_flag (instr_extest),
    .ext_rst   (ext_rst),
    .int_rst   (int_rst)
  );
endmodule

// File: rtl/bs_bidir_chain_chk.sv
`timescale 1ns/1ps
module bs_bidir_chain_chk #(
  parameter int NPIN = 8,
  parameter int NCTL = 5
) (
  input logic            tck,
  input logic            clk,
  input logic            por,
  input logic            tap_reset,
  input logic            update_dr,
  input logic            instr_extest,
  input logic            instr_highz,
  input logic            ext_rst,
  input logic            int_rst,
  input logic [NPIN-1:0] core_out,
  input logic [NPIN-1:0] core_oe,
  input logic [NPIN-1:0] pad_out,
  input logic [NPIN-1:0] pad_oe
);
  a_r1_func_pass: assert property (@(posedge clk) disable iff (por)
    (!instr_extest && !instr_highz) |-> (pad_out == core_out && pad_oe == core_oe));

  a_r4_pads_hold: assert property (@(posedge tck) disable iff (por || tap_reset)
    (instr_extest && !instr_highz && $past(instr_extest) && !$past(instr_highz) && !update_dr)
      |-> $stable(pad_out));

  for (genvar i = 0; i + NCTL < NPIN; i++) begin : g_grp
    a_r5_group_oe: assert property (@(posedge clk) disable iff (por || tap_reset)
      (instr_extest && !instr_highz) |-> (pad_oe[i] == pad_oe[i+NCTL]));
  end

  a_r6_highz_off: assert property (@(posedge clk) disable iff (por)
    instr_highz |-> (pad_oe == '0));

  a_r7_tlr_off: assert property (@(posedge clk) disable iff (por)
    (tap_reset && instr_extest && !instr_highz) |-> (pad_oe == '0));

  a_r9_fire_needs_silence: assert property (@(posedge clk) disable iff (por)
    $rose(int_rst) |-> !$past(ext_rst));

  a_r10_ext_clears: assert property (@(posedge clk) disable iff (por)
    ext_rst |=> !int_rst);
endmodule

bind bs_bidir_chain bs_bidir_chain_chk #(.NPIN(NPIN), .NCTL(NCTL)) u_chk (.*);

// File: tb/sim_bs_bidir_chain.sv
`timescale 1ns/1ps
module sim_bs_bidir_chain;
  localparam int NPIN  = 8;
  localparam int NCTL  = 5;
  localparam int SYNC  = 2;
  localparam int NCELL = 2 * NPIN + NCTL;
  localparam int MAXCYC = 20000;

  logic tck = 0, clk = 0;
  logic tdi = 0, por = 1, tap_reset = 0;
  logic capture_dr = 0, shift_dr = 0, update_dr = 0, dr_sel = 1;
  logic instr_extest = 0, instr_highz = 0, ext_rst = 0;
  logic [NPIN-1:0] core_out = '0, core_oe = '0, pad_in = '0;
  logic tdo, int_rst;
  logic [NPIN-1:0] pad_out, pad_oe;

  always #10 clk = ~clk;
  always #50 tck = ~tck;

  bs_bidir_chain #(.NPIN(NPIN), .NCTL(NCTL), .SYNC(SYNC), .LIMIT(10)) u0 (.*);

  int  n_chk = 0, n_fail = 0;
  bit  done = 0, mon_en = 0;
  logic exp_q[$];
  logic [NPIN-1:0] m_out = '0;
  logic [NCTL-1:0] m_ctl = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NCELL-1:0] mkvec(input logic [NPIN-1:0] o, input logic [NCTL-1:0] c);
    logic [NCELL-1:0] v = '0;
    for (int i = 0; i < NPIN; i++) v[2*i+1] = o[i];
    for (int k = 0; k < NCTL; k++) v[2*NPIN+k] = c[k];
    return v;
  endfunction

  function automatic logic [NPIN-1:0] oe_of(input logic [NCTL-1:0] c);
    logic [NPIN-1:0] r;
    for (int i = 0; i < NPIN; i++) r[i] = c[i % NCTL];
    return r;
  endfunction

  // expected capture image: pad input, current drive value, current enable
  function automatic logic [NCELL-1:0] capvec(input logic [NPIN-1:0] pin);
    logic [NCELL-1:0] v = mkvec(m_out, m_ctl);
    for (int i = 0; i < NPIN; i++) v[2*i] = pin[i];
    return v;
  endfunction

  // driver: pushes the expected serial stream, then walks the tap signals
  task automatic scan(input logic [NCELL-1:0] v, input bit cap, input bit upd, input logic [NCELL-1:0] expv);
    @(posedge tck); #1;
    if (cap) begin
      for (int j = 0; j < NCELL; j++) exp_q.push_back(expv[j]);
      capture_dr = 1;
      @(posedge tck); #1;
      capture_dr = 0;
      mon_en = 1;
    end
    shift_dr = 1;
    for (int j = 0; j < NCELL; j++) begin
      tdi = v[j];
      @(posedge tck); #1;
    end
    shift_dr = 0;
    mon_en = 0;
    if (upd) begin
      update_dr = 1;
      @(posedge tck); #1;
      update_dr = 0;
    end
  endtask

  task automatic do_update();
    @(posedge tck); #1;
    update_dr = 1;
    @(posedge tck); #1;
    update_dr = 0;
  endtask

  // monitor: compares tdo against the scoreboard mid-period
  always @(negedge tck) begin
    if (mon_en && shift_dr) begin
      if (exp_q.size() == 0) chk(1'b0, "R3 queue underrun", 32'(tdo), 32'h0);
      else begin
        logic e;
        e = exp_q.pop_front();
        chk(tdo === e, "R2/R3 captured bit", 32'(tdo), 32'(e));
      end
    end
  end

  initial begin
    #(MAXCYC * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [NCELL-1:0] v;
    repeat (3) @(posedge clk);
    #1;
    chk(pad_oe == '0, "R8 reset oe", 32'(pad_oe), 0);
    chk(int_rst == 0, "R11 reset int_rst", 32'(int_rst), 0);

    // R8: scan activity under power-on reset is ignored
    instr_extest = 1;
    scan(mkvec('1, '1), 0, 1, '0);
    chk(pad_oe == '0, "R8 oe ignored", 32'(pad_oe), 0);
    chk(pad_out == '0, "R8 out ignored", 32'(pad_out), 0);
    @(negedge clk) instr_extest = 0;
    repeat (5) @(posedge clk);
    por = 0;
    repeat (20) @(posedge clk);
    #1 chk(int_rst == 0, "R11 exit under por", 32'(int_rst), 0);

    // R1: functional pass-through
    core_out = 8'hA5; core_oe = 8'h3C; #1;
    chk(pad_out == 8'hA5 && pad_oe == 8'h3C, "R1 func a", {pad_out, pad_oe}, 32'hA53C);
    core_out = 8'h5A; core_oe = 8'hC3; #1;
    chk(pad_out == 8'h5A && pad_oe == 8'hC3, "R1 func b", {pad_out, pad_oe}, 32'h5AC3);

    // R5: drive and grouped enables
    instr_extest = 1;
    scan(mkvec(8'h96, 5'b00101), 0, 1, '0);
    m_out = 8'h96; m_ctl = 5'b00101;
    chk(pad_out == m_out, "R5 out a", 32'(pad_out), 32'(m_out));
    chk(pad_oe == oe_of(m_ctl), "R5 oe a", 32'(pad_oe), 32'(oe_of(m_ctl)));

    // R4: shifting leaves pads alone until update
    scan(mkvec(8'h3B, 5'b11010), 0, 0, '0);
    chk(pad_out == m_out, "R4 out held", 32'(pad_out), 32'(m_out));
    chk(pad_oe == oe_of(m_ctl), "R4 oe held", 32'(pad_oe), 32'(oe_of(m_ctl)));
    do_update();
    m_out = 8'h3B; m_ctl = 5'b11010;
    chk(pad_out == m_out, "R5 out b", 32'(pad_out), 32'(m_out));
    chk(pad_oe == oe_of(m_ctl), "R5 oe b", 32'(pad_oe), 32'(oe_of(m_ctl)));

    // R3: capture, shifting the same image back in
    pad_in = 8'hC6;
    scan(mkvec(m_out, m_ctl), 1, 1, capvec(8'hC6));
    chk(pad_out == m_out, "R3 pads kept", 32'(pad_out), 32'(m_out));
    chk(exp_q.size() == 0, "R3 stream length", exp_q.size(), 0);

    // R7: test reset clears latches
    @(posedge tck); #1 tap_reset = 1;
    @(posedge tck); #1 tap_reset = 0;
    m_out = '0; m_ctl = '0;
    chk(pad_oe == '0, "R7 oe cleared", 32'(pad_oe), 0);
    chk(pad_out == '0, "R7 out cleared", 32'(pad_out), 0);
    pad_in = 8'h71;
    scan(mkvec('0, '0), 1, 1, capvec(8'h71));

    // R9: late exit fires on edge SYNC+10
    @(negedge clk) instr_extest = 0;
    repeat (SYNC + 9) @(posedge clk);
    #1 chk(int_rst == 0, "R9 quiet at SYNC+9", 32'(int_rst), 0);
    @(posedge clk); #1 chk(int_rst == 1, "R9 fires at SYNC+10", 32'(int_rst), 1);
    ext_rst = 1;
    @(posedge clk); #1 ext_rst = 0;
    chk(int_rst == 0, "R10 ext clears", 32'(int_rst), 0);

    // R6 and R10: exit into float mode, external reset within window
    instr_extest = 1;
    scan(mkvec('1, '1), 0, 1, '0);
    chk(pad_oe == '1, "R5 all on", 32'(pad_oe), 32'hFF);
    @(negedge clk) begin instr_extest = 0; instr_highz = 1; end
    #1 chk(pad_oe == '0, "R6 float oe", 32'(pad_oe), 0);
    chk(pad_out == core_out, "R6 float out", 32'(pad_out), 32'(core_out));
    repeat (SYNC + 7) @(posedge clk);
    #1 ext_rst = 1;
    @(posedge clk); #1 ext_rst = 0;
    repeat (20) @(posedge clk);
    #1 chk(int_rst == 0, "R10 in window", 32'(int_rst), 0);
    chk(pad_oe == '0, "R6 float held", 32'(pad_oe), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule